// File: doc/BRIEF.md
# Power-Down Clock Controller

This block decides how deeply a processor core sleeps and what wakes it. Software writes a 16-bit control word. Bits 15 down to 10 of that word hold a 6-bit sleep code. The controller decodes the code and picks one of three sleep depths:

- **Light sleep** gates only the CPU clock. The DMA clock and the interrupt logic keep running.
- **Medium sleep** also stops the chip clock and turns off the PLL output.
- **Deep sleep** also stops the PLL input, so the PLL loses lock.

Light sleep ends on an interrupt. Medium and deep sleep end only on a device reset. After any reset the controller holds every clock off until the PLL lock input has been high for a set number of consecutive cycles. For that reason, leaving deep sleep takes longer than leaving medium sleep.

While a debugger is attached, every sleep request is held off. All clock gates are glitch-free: each enable is retimed on the falling edge of the reference clock and ANDed with that clock.

Top module: `pwrdn_clk_ctrl`

## Requirements
- R1: While reset is asserted, the control word reads 0, `locking` is 1, `pd_level` is 0, both clock enables are 0, `pll_out_en` is 0 and `pll_in_en` is 1.
- R2: Sleep code 000000 keeps the core running: `pd_level` 0, both clocks on, `pll_out_en` and `pll_in_en` both 1. A sleep code written in one cycle takes effect at the following clock edge.
- R3: Sleep code 001001 enters light sleep (`pd_level`=1). Only a pending interrupt whose enable bit is set wakes the core.
- R4: Sleep code 010001 enters light sleep (`pd_level`=1). Any pending interrupt wakes the core, whether its enable bit is set or not.
- R5: A wake from light sleep returns `pd_level` to 0 and restarts the CPU clock. It clears control bits 15:10 to 000000 and leaves bits 9:0 unchanged.
- R6: Sleep code 011010 enters medium sleep (`pd_level`=2): both clocks off, `pll_out_en` 0, `pll_in_en` 1. Interrupts do not end it; only reset does.
- R7: Sleep code 011100 enters deep sleep (`pd_level`=3): both clocks off and both PLL enables 0. Only reset ends it.
- R8: Every sleep code other than the five listed in R2, R3, R4, R6 and R7 leaves `pd_level` at 0 and all clocks running.
- R9: While `dbg_attached` is 1, no sleep code causes entry into any sleep depth. Once it drops, a sleep code still held in the control word takes effect at the next edge.
- R10: In light sleep the CPU clock is off, while the DMA clock, `pll_out_en` and `pll_in_en` stay on.
- R11: A clock enable changes only while the reference clock is low, so a gated clock never emits a partial pulse.
- R12: After reset, clocks are released only after `pll_locked` has been sampled high on LOCK_CYCLES consecutive edges. A low sample restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous device reset, active low |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write value; sleep code in bits 15:10 |
| ctrl_rd | output | 16 | Current control word |
| dbg_attached | input | 1 | Debugger present; masks sleep entry |
| irq_pending | input | IRQ_W | Pending interrupt lines |
| irq_enable | input | IRQ_W | Interrupt enable mask |
| pll_locked | input | 1 | PLL lock indication |
| pll_in_en | output | 1 | PLL input clock enable |
| pll_out_en | output | 1 | PLL output clock enable to the chip |
| locking | output | 1 | Waiting for PLL lock after reset |
| pd_level | output | 2 | Sleep depth: 0 run, 1 light, 2 medium, 3 deep |
| cpu_clk_on | output | 1 | Retimed CPU clock enable |
| dma_clk_on | output | 1 | Retimed DMA clock enable |
| cpu_gclk | output | 1 | Gated CPU clock |
| dma_gclk | output | 1 | Gated DMA clock |

## Verification
The bench uses IRQ_W=4 and LOCK_CYCLES=4. The narrow interrupt vector allows every pair of pending and enable patterns (256 pairs) to be tried against both light-sleep codes. The short lock window allows exact counting of the reset-exit delay for medium and deep sleep, including a restart caused by a lock drop. Every one of the 64 sleep codes is swept both with and without the debugger attached. For each code the bench checks the sleep depth, the PLL enables and the number of gated-clock edges.

// File: rtl/pwrdn_clk_ctrl.sv
module pwrdn_clk_ctrl #(
  parameter int IRQ_W       = 8,
  parameter int LOCK_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  output logic [15:0]      ctrl_rd,
  input  logic             dbg_attached,
  input  logic [IRQ_W-1:0] irq_pending,
  input  logic [IRQ_W-1:0] irq_enable,
  input  logic             pll_locked,
  output logic             pll_in_en,
  output logic             pll_out_en,
  output logic             locking,
  output logic [1:0]       pd_level,
  output logic             cpu_clk_on,
  output logic             dma_clk_on,
  output logic             cpu_gclk,
  output logic             dma_gclk
);

  localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

  localparam logic [5:0] C_PD1_EN  = 6'b001001;
  localparam logic [5:0] C_PD1_ANY = 6'b010001;
  localparam logic [5:0] C_PD2     = 6'b011010;
  localparam logic [5:0] C_PD3     = 6'b011100;

  typedef enum logic [2:0] {S_LOCK, S_RUN, S_LIGHT, S_MED, S_DEEP} state_t;

  state_t           state_q, state_d;
  logic [15:0]      ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             any_wake_q;
  logic [5:0]       code;
  logic             wake;
  logic             lock_done;

  assign code      = ctrl_q[15:10];
  assign lock_done = pll_locked && (cnt_q == CNT_LAST);
  assign wake      = (state_q == S_LIGHT) &&
                     (any_wake_q ? |irq_pending : |(irq_pending & irq_enable));

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_LOCK:  if (lock_done) state_d = S_RUN;
      S_RUN:   if (!dbg_attached) begin
                 if (code == C_PD1_EN || code == C_PD1_ANY) state_d = S_LIGHT;
                 else if (code == C_PD2)                     state_d = S_MED;
                 else if (code == C_PD3)                     state_d = S_DEEP;
               end
      S_LIGHT: if (wake) state_d = S_RUN;
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_LOCK;
      ctrl_q     <= '0;
      cnt_q      <= '0;
      any_wake_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (wr_en)     ctrl_q         <= wr_data;
      else if (wake) ctrl_q[15:10]  <= 6'b000000;
      if (state_q == S_LOCK && pll_locked && !lock_done) cnt_q <= cnt_q + 1'b1;
      else                                                cnt_q <= '0;
      if (state_q == S_RUN && state_d == S_LIGHT) any_wake_q <= (code == C_PD1_ANY);
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_clk_on <= 1'b0;
      dma_clk_on <= 1'b0;
    end else begin
      cpu_clk_on <= (state_q == S_RUN);
      dma_clk_on <= (state_q == S_RUN) || (state_q == S_LIGHT);
    end
  end

  assign cpu_gclk   = clk & cpu_clk_on;
  assign dma_gclk   = clk & dma_clk_on;
  assign pll_out_en = (state_q == S_RUN) || (state_q == S_LIGHT);
  assign pll_in_en  = (state_q != S_DEEP);
  assign locking    = (state_q == S_LOCK);
  assign ctrl_rd    = ctrl_q;

  always_comb begin
    case (state_q)
      S_LIGHT: pd_level = 2'd1;
      S_MED:   pd_level = 2'd2;
      S_DEEP:  pd_level = 2'd3;
      default: pd_level = 2'd0;
    endcase
  end

endmodule

// File: rtl/pwrdn_clk_ctrl_chk.sv
module pwrdn_clk_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] ctrl_rd,
  input logic        dbg_attached,
  input logic        pll_locked,
  input logic        pll_in_en,
  input logic        pll_out_en,
  input logic        locking,
  input logic [1:0]  pd_level,
  input logic        cpu_clk_on,
  input logic        dma_clk_on
);

  logic [5:0] code;
  logic       known;
  assign code  = ctrl_rd[15:10];
  assign known = (code == 6'b001001) || (code == 6'b010001) ||
                 (code == 6'b011010) || (code == 6'b011100);

  a_r3_light_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_level == 2'd0 && !locking && !dbg_attached && !wr_en && code == 6'b001001)
      |=> pd_level == 2'd1);

  a_r5_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pd_level) == 2'd1 && pd_level == 2'd0 && !$past(wr_en))
      |-> ctrl_rd[15:10] == 6'b000000);

  a_r6_deep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_level >= 2'd2) |=> $stable(pd_level));

  a_r7_deep_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_level == 2'd3 && $past(pd_level) == 2'd3)
      |-> (!cpu_clk_on && !dma_clk_on && !pll_in_en && !pll_out_en));

  a_r8_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_level == 2'd0 && !locking && !wr_en && !known) |=> pd_level == 2'd0);

  a_r9_dbg_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_level == 2'd0 && dbg_attached) |=> pd_level == 2'd0);

  a_r10_light_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_level == 2'd1 && $past(pd_level) == 2'd1)
      |-> (!cpu_clk_on && dma_clk_on && pll_out_en && pll_in_en));

  a_r12_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (locking && !pll_locked) |=> locking);

  always @(cpu_clk_on)
    if (rst_n === 1'b1)
      a_r11_cpu_gate_low: assert (clk === 1'b0) else $error("cpu enable moved while clk high");

  always @(dma_clk_on)
    if (rst_n === 1'b1)
      a_r11_dma_gate_low: assert (clk === 1'b0) else $error("dma enable moved while clk high");

endmodule

bind pwrdn_clk_ctrl pwrdn_clk_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl_rd(ctrl_rd),
  .dbg_attached(dbg_attached), .pll_locked(pll_locked), .pll_in_en(pll_in_en),
  .pll_out_en(pll_out_en), .locking(locking), .pd_level(pd_level),
  .cpu_clk_on(cpu_clk_on), .dma_clk_on(dma_clk_on)
);

// File: tb/pwrdn_clk_ctrl_bench.sv
module pwrdn_clk_ctrl_bench;
  localparam int IRQ_W = 4;
  localparam int LOCK  = 4;
  localparam int DLY   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl_rd;
  logic dbg_attached = 1'b0;
  logic [IRQ_W-1:0] irq_pending = '0, irq_enable = '0;
  logic pll_locked = 1'b0;
  logic pll_in_en, pll_out_en, locking, cpu_clk_on, dma_clk_on, cpu_gclk, dma_gclk;
  logic [1:0] pd_level;

  int checks = 0, fails = 0, cpu_edges = 0, dma_edges = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge cpu_gclk) cpu_edges++;
  always @(posedge dma_gclk) dma_edges++;

  pwrdn_clk_ctrl #(.IRQ_W(IRQ_W), .LOCK_CYCLES(LOCK)) u_pwrdn_clk_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl_rd(ctrl_rd),
    .dbg_attached(dbg_attached), .irq_pending(irq_pending), .irq_enable(irq_enable),
    .pll_locked(pll_locked), .pll_in_en(pll_in_en), .pll_out_en(pll_out_en),
    .locking(locking), .pd_level(pd_level), .cpu_clk_on(cpu_clk_on),
    .dma_clk_on(dma_clk_on), .cpu_gclk(cpu_gclk), .dma_gclk(dma_gclk));

  task automatic tick();
    @(posedge clk); #7;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int level_of(input logic [5:0] c);
    case (c)
      6'b001001, 6'b010001: return 1;
      6'b011010:            return 2;
      6'b011100:            return 3;
      default:              return 0;
    endcase
  endfunction

  task automatic recover();
    rst_n = 1'b0; wr_en = 1'b0; dbg_attached = 1'b0;
    irq_pending = '0; irq_enable = '0;
    tick();
    rst_n = 1'b1; pll_locked = 1'b1;
    repeat (LOCK) tick();
  endtask

  task automatic write_ctrl(input logic [15:0] v);
    wr_en = 1'b1; wr_data = v;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic exit_time(input logic [5:0] c, input bit deep, output int n);
    write_ctrl({c, 10'h0F0});
    tick();
    if (deep) pll_locked = 1'b0;
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    n = 0;
    while (n < 50) begin
      tick(); n++;
      if (deep && n == DLY) pll_locked = 1'b1;
      if (!locking && cpu_clk_on) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, t2, t3;
    tick(); tick();
    chk(ctrl_rd == 0, "R1 ctrl", ctrl_rd, 0);
    chk(locking == 1, "R1 locking", locking, 1);
    chk(pd_level == 0, "R1 level", pd_level, 0);
    chk(!cpu_clk_on && !dma_clk_on, "R1 clocks", cpu_clk_on + dma_clk_on, 0);
    chk(pll_in_en && !pll_out_en, "R1 pll", {pll_in_en, pll_out_en}, 2);

    rst_n = 1'b1;
    repeat (3) tick();
    chk(locking == 1, "R12 unlocked hold", locking, 1);
    pll_locked = 1'b1; tick(); tick();
    pll_locked = 1'b0; tick();
    pll_locked = 1'b1;
    n = 0;
    while (n < 50) begin tick(); n++; if (!locking) break; end
    chk(n == LOCK, "R12 restart count", n, LOCK);
    chk(cpu_clk_on && dma_clk_on && pll_out_en, "R12 release", cpu_clk_on, 1);

    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 64; c++) begin
        int lv, exp_lv;
        lv = level_of(6'(c));
        exp_lv = d ? 0 : lv;
        dbg_attached = d[0];
        write_ctrl({6'(c), 10'h2A5});
        tick();
        chk(pd_level == exp_lv, (lv == 0 && c != 0) ? "R8 reserved level" :
            (d ? "R9 dbg mask" : "R2 level"), pd_level, exp_lv);
        chk(pll_out_en == (exp_lv < 2), "R6 pll_out_en", pll_out_en, exp_lv < 2);
        chk(pll_in_en == (exp_lv != 3), "R7 pll_in_en", pll_in_en, exp_lv != 3);
        cpu_edges = 0; dma_edges = 0;
        repeat (4) tick();
        chk(cpu_edges == (exp_lv == 0 ? 4 : 0), "R10 cpu gclk edges", cpu_edges, exp_lv == 0 ? 4 : 0);
        chk(dma_edges == (exp_lv < 2 ? 4 : 0), "R10 dma gclk edges", dma_edges, exp_lv < 2 ? 4 : 0);
        if (exp_lv >= 2) begin
          irq_pending = '1; irq_enable = '1;
          tick();
          chk(pd_level == exp_lv, "R6 irq ignored", pd_level, exp_lv);
        end
        if (d && lv != 0) begin
          dbg_attached = 1'b0;
          tick();
          chk(pd_level == lv, "R9 after detach", pd_level, lv);
        end
        recover();
      end
    end

    exit_time(6'b011010, 1'b0, t2);
    chk(t2 == LOCK, "R6 exit time", t2, LOCK);
    chk(ctrl_rd == 0, "R6 reset clears", ctrl_rd, 0);
    exit_time(6'b011100, 1'b1, t3);
    chk(t3 == DLY + LOCK, "R7 exit time", t3, DLY + LOCK);
    chk(t3 > t2, "R7 slower than medium", t3, t2 + 1);

    for (int v = 0; v < 2; v++) begin
      for (int p = 0; p < 16; p++) begin
        for (int e = 0; e < 16; e++) begin
          logic [5:0] c;
          bit w;
          c = v ? 6'b010001 : 6'b001001;
          w = v ? (p != 0) : ((p & e) != 0);
          irq_pending = '0; irq_enable = '0;
          write_ctrl({c, 10'h155});
          tick();
          chk(pd_level == 1, v ? "R4 entry" : "R3 entry", pd_level, 1);
          irq_pending = 4'(p); irq_enable = 4'(e);
          tick();
          chk(pd_level == (w ? 0 : 1), v ? "R4 wake" : "R3 wake", pd_level, w ? 0 : 1);
          if (!w) begin
            irq_pending = '1; irq_enable = '1;
            tick();
          end
          chk(ctrl_rd == {6'b0, 10'h155}, "R5 field cleared", ctrl_rd, {6'b0, 10'h155});
          chk(cpu_clk_on == 1, "R5 cpu restart", cpu_clk_on, 1);
          irq_pending = '0; irq_enable = '0;
          tick();
          chk(pd_level == 0, "R5 stays awake", pd_level, 0);
        end
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule